// File: doc/BRIEF.md
# Four-Bit Signed Code Translator

This block rewrites a 4-bit signed code word from one encoding into another, all in combinational logic. It knows four encodings: sign-magnitude, excess-8, one's complement and two's complement. The caller supplies a code word and two format selects, one for the source and one for the destination. The block returns the translated code word and two flags. One flag says that the value has no code in the destination encoding. The other says that the input is the negative-zero code of a format that has one.

Inside, the input is first turned into a 5-bit two's-complement value. A small control stage inspects that value and the two selects, and sends a bundle of strobes to the encoder. The encoder then builds the destination code. Because both zero codes decode to 0, and a zero value is always emitted as the positive code, negative zero never appears at the output. The value −8 exists only in two's complement and excess-8. When the destination is one of the other two encodings, −8 is reported as unrepresentable instead of being wrapped.

Top module: `sncvt_top`

## Requirements
- R1: Format select encoding is 0 = sign-magnitude, 1 = excess-8, 2 = one's complement, 3 = two's complement. In sign-magnitude, bit 3 is the sign (1 = negative) and bits 2:0 hold the magnitude, so −6 is 1110.
- R2: In excess-8 the code equals the value plus 8, so codes 0..15 stand for −8..+7.
- R3: In one's complement a nonnegative value is its plain binary code, and a negative value is the bitwise inverse of the code of its magnitude.
- R4: In two's complement a negative value is the inverse of its magnitude's code plus 1, covering −8..+7. When both selects are two's complement, the output equals the input.
- R5: Whenever the value is representable in the destination, the output code decodes in that format to the same value as the input decodes in the source format.
- R6: When the decoded value is −8 and the destination is sign-magnitude or one's complement, `codeOut` is 0000 and `unrepresentable` is 1. In every other case `unrepresentable` is 0.
- R7: A zero value is always emitted as the positive-zero code: 0000 for sign-magnitude, one's complement and two's complement, and 1000 for excess-8. The output is never 1000 in sign-magnitude or 1111 in one's complement.
- R8: `negZeroIn` is 1 exactly when the source is sign-magnitude with code 1000, or one's complement with code 1111.
- R9: For any representable conversion, translating the output back to the source format yields the original code, unless the original was a negative-zero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| codeIn | input | 4 | Code word to translate |
| srcFmt | input | 2 | Encoding of codeIn (R1 encoding) |
| dstFmt | input | 2 | Encoding wanted at codeOut |
| codeOut | output | 4 | Translated code word |
| unrepresentable | output | 1 | Value has no code in the destination encoding |
| negZeroIn | output | 1 | Input is a negative-zero code |

## Verification
The block holds no state. A wrong intermediate value therefore shows up at `codeOut` or at a flag as soon as the inputs settle, within the same evaluation. A wrong decode of one source code corrupts every destination that code is sent to. A wrong −8 or zero decision shows up only at the range edges and at the redundant zero codes. For that reason the sweep covers every code in every format pair and also translates each result back to its source format.

// File: rtl/sncvt_pkg.sv
package sncvt_pkg;

  typedef enum logic [1:0] {
    FMT_SIGNMAG = 2'd0,
    FMT_EXCESS  = 2'd1,
    FMT_ONES    = 2'd2,
    FMT_TWOS    = 2'd3
  } fmtSel_e;

  // strobes from control to the encoding datapath
  typedef struct packed {
    logic negate;     // value below zero: build the negative form
    logic forceZero;  // drive an all-zero code
    logic unrep;      // value has no code in the destination
    logic negZero;    // input was a negative-zero code
  } sncStrobe_t;

endpackage

// File: rtl/sncvt_decode.sv
module sncvt_decode
  import sncvt_pkg::*;
#(
  parameter int W = 4,
  localparam int VW = W + 1
) (
  input  logic [W-1:0]  codeIn,
  input  fmtSel_e       srcFmt,
  output logic [VW-1:0] valueOut
);

  localparam logic [VW-1:0] EXCESS_V = VW'(1) << (W - 1);

  logic [VW-1:0] smMag;
  logic [VW-1:0] onesMag;
  logic [VW-1:0] plainV;

  assign smMag   = {2'b00, codeIn[W-2:0]};
  assign onesMag = {1'b0, ~codeIn};
  assign plainV  = {1'b0, codeIn};

  always_comb begin
    case (srcFmt)
      FMT_SIGNMAG: valueOut = codeIn[W-1] ? (~smMag + VW'(1)) : smMag;
      FMT_EXCESS:  valueOut = plainV - EXCESS_V;
      FMT_ONES:    valueOut = codeIn[W-1] ? (~onesMag + VW'(1)) : plainV;
      FMT_TWOS:    valueOut = {codeIn[W-1], codeIn};
      default:     valueOut = '0;
    endcase
  end

endmodule

// File: rtl/sncvt_ctrl.sv
module sncvt_ctrl
  import sncvt_pkg::*;
#(
  parameter int W = 4,
  localparam int VW = W + 1
) (
  input  logic [W-1:0]  codeIn,
  input  fmtSel_e       srcFmt,
  input  fmtSel_e       dstFmt,
  input  logic [VW-1:0] valueIn,
  output sncStrobe_t    strobe
);

  localparam logic [VW-1:0] MIN_V   = {2'b11, {(W-1){1'b0}}};
  localparam logic [W-1:0]  SM_NEG0 = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]  OC_NEG0 = {W{1'b1}};

  logic narrowDst;
  logic isMin;

  assign narrowDst = (dstFmt == FMT_SIGNMAG) || (dstFmt == FMT_ONES);
  assign isMin     = (valueIn == MIN_V);

  always_comb begin
    strobe.unrep     = narrowDst && isMin;
    strobe.forceZero = narrowDst && isMin;
    strobe.negate    = valueIn[VW-1];
    strobe.negZero   = ((srcFmt == FMT_SIGNMAG) && (codeIn == SM_NEG0)) ||
                       ((srcFmt == FMT_ONES) && (codeIn == OC_NEG0));
  end

endmodule

// File: rtl/sncvt_encode.sv
module sncvt_encode
  import sncvt_pkg::*;
#(
  parameter int W = 4,
  localparam int VW = W + 1
) (
  input  logic [VW-1:0] valueIn,
  input  fmtSel_e       dstFmt,
  input  sncStrobe_t    strobe,
  output logic [W-1:0]  codeOut
);

  localparam logic [VW-1:0] EXCESS_V = VW'(1) << (W - 1);

  logic [W-1:0] magW;

  assign magW = strobe.negate ? W'(~valueIn + VW'(1)) : valueIn[W-1:0];

  always_comb begin
    if (strobe.forceZero) begin
      codeOut = '0;
    end else begin
      case (dstFmt)
        FMT_SIGNMAG: codeOut = {strobe.negate, magW[W-2:0]};
        FMT_EXCESS:  codeOut = W'(valueIn + EXCESS_V);
        FMT_ONES:    codeOut = strobe.negate ? ~magW : magW;
        FMT_TWOS:    codeOut = valueIn[W-1:0];
        default:     codeOut = '0;
      endcase
    end
  end

endmodule

// File: rtl/sncvt_top.sv
module sncvt_top
  import sncvt_pkg::*;
(
  input  logic [3:0] codeIn,
  input  logic [1:0] srcFmt,
  input  logic [1:0] dstFmt,
  output logic [3:0] codeOut,
  output logic       unrepresentable,
  output logic       negZeroIn
);

  localparam int W  = 4;
  localparam int VW = W + 1;

  fmtSel_e       srcSel;
  fmtSel_e       dstSel;
  logic [VW-1:0] midValue;
  sncStrobe_t    strobe;

  assign srcSel = fmtSel_e'(srcFmt);
  assign dstSel = fmtSel_e'(dstFmt);

  sncvt_decode #(.W(W)) decode_i (
    .codeIn   (codeIn),
    .srcFmt   (srcSel),
    .valueOut (midValue)
  );

  sncvt_ctrl #(.W(W)) ctrl_i (
    .codeIn  (codeIn),
    .srcFmt  (srcSel),
    .dstFmt  (dstSel),
    .valueIn (midValue),
    .strobe  (strobe)
  );

  sncvt_encode #(.W(W)) encode_i (
    .valueIn (midValue),
    .dstFmt  (dstSel),
    .strobe  (strobe),
    .codeOut (codeOut)
  );

  assign unrepresentable = strobe.unrep;
  assign negZeroIn       = strobe.negZero;

endmodule

// File: rtl/sncvt_chk.sv
module sncvt_chk (
  input logic [3:0] codeIn,
  input logic [1:0] srcFmt,
  input logic [1:0] dstFmt,
  input logic [3:0] codeOut,
  input logic       unrepresentable,
  input logic       negZeroIn
);

  always_comb begin
    AST_UNREP_GIVES_ZERO: assert (!unrepresentable || codeOut == 4'b0000)
      else $error("unrepresentable with nonzero code"); // R6
    AST_UNREP_NARROW_ONLY: assert (!unrepresentable || dstFmt == 2'd0 || dstFmt == 2'd2)
      else $error("unrepresentable for a full-range destination"); // R6
    AST_NO_NEG_ZERO_OUT: assert (!(dstFmt == 2'd0 && codeOut == 4'b1000) &&
                                 !(dstFmt == 2'd2 && codeOut == 4'b1111))
      else $error("negative zero emitted"); // R7
    AST_NEGZERO_SOURCE: assert (!negZeroIn || srcFmt == 2'd0 || srcFmt == 2'd2)
      else $error("negative zero flagged for a format without one"); // R8
    AST_TWOS_PASSTHRU: assert (!(srcFmt == 2'd3 && dstFmt == 2'd3) || codeOut == codeIn)
      else $error("two's complement pass-through altered"); // R4
    AST_SAME_FMT_KEEP: assert (srcFmt != dstFmt || negZeroIn || codeOut == codeIn)
      else $error("same-format translation altered the code"); // R5
  end

endmodule

bind sncvt_top sncvt_chk chk_i (
  .codeIn          (codeIn),
  .srcFmt          (srcFmt),
  .dstFmt          (dstFmt),
  .codeOut         (codeOut),
  .unrepresentable (unrepresentable),
  .negZeroIn       (negZeroIn)
);

// File: tb/sncvt_top_tb_top.sv
module sncvt_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] codeIn = '0;
  logic [1:0] srcFmt = '0;
  logic [1:0] dstFmt = '0;
  logic [3:0] codeOut;
  logic       unrepresentable;
  logic       negZeroIn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sncvt_top dut_i (
    .codeIn          (codeIn),
    .srcFmt          (srcFmt),
    .dstFmt          (dstFmt),
    .codeOut         (codeOut),
    .unrepresentable (unrepresentable),
    .negZeroIn       (negZeroIn)
  );

  // value of a code in a format, per R1..R4
  function automatic int refValue(int fmt, int code);
    case (fmt)
      0:       return (code >= 8) ? -(code - 8) : code;
      1:       return code - 8;
      2:       return (code >= 8) ? -(15 - code) : code;
      default: return (code >= 8) ? code - 16 : code;
    endcase
  endfunction

  function automatic bit refUnrep(int fmt, int val);
    return (val == -8) && (fmt == 0 || fmt == 2);
  endfunction

  // code for a value, positive zero always (R7)
  function automatic int refCode(int fmt, int val);
    if (refUnrep(fmt, val)) return 0;
    case (fmt)
      0:       return (val < 0) ? 8 - val : val;
      1:       return val + 8;
      2:       return (val < 0) ? 15 + val : val;
      default: return (val < 0) ? 16 + val : val;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(int s, int d, int c);
    @(negedge clk);
    srcFmt = 2'(s);
    dstFmt = 2'(d);
    codeIn = 4'(c);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // reset-time state: all-zero inputs, sign-magnitude to sign-magnitude
    #1;
    check("R7", int'(codeOut), 0, "initial output code");
    check("R6", int'(unrepresentable), 0, "initial unrepresentable");
    check("R8", int'(negZeroIn), 0, "initial negative-zero flag");

    // spot cases from the requirements
    drive(3, 0, 4'b1010);            // -6 two's -> sign-magnitude 1110
    check("R1", int'(codeOut), 4'b1110, "-6 in sign-magnitude");
    drive(3, 1, 4'b1000);            // -8 two's -> excess 0000
    check("R2", int'(codeOut), 0, "-8 in excess-8");
    drive(3, 2, 4'b1000);            // -8 to one's: unrepresentable
    check("R6", int'(unrepresentable), 1, "-8 into one's complement flag");
    check("R6", int'(codeOut), 0, "-8 into one's complement code");
    drive(2, 1, 4'b1111);            // one's -0 -> excess +0 code 1000
    check("R7", int'(codeOut), 4'b1000, "negative zero into excess-8");
    check("R8", int'(negZeroIn), 1, "one's negative zero flag");

    // exhaustive sweep over all format pairs and codes
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 4; d++) begin
        for (int c = 0; c < 16; c++) begin
          int v;
          int expCode;
          bit expUnrep;
          bit expNz;
          string tag;
          int fwd;
          v        = refValue(s, c);
          expUnrep = refUnrep(d, v);
          expCode  = refCode(d, v);
          expNz    = (s == 0 && c == 8) || (s == 2 && c == 15);
          if (expUnrep)    tag = "R6";
          else if (v == 0) tag = "R7";
          else if (d == 0) tag = "R1";
          else if (d == 1) tag = "R2";
          else if (d == 2) tag = "R3";
          else             tag = "R4";
          drive(s, d, c);
          fwd = int'(codeOut);
          check(tag, fwd, expCode, $sformatf("code src%0d dst%0d in%0d", s, d, c));
          check("R6", int'(unrepresentable), int'(expUnrep), $sformatf("flag src%0d dst%0d in%0d", s, d, c));
          check("R8", int'(negZeroIn), int'(expNz), $sformatf("negzero src%0d in%0d", s, c));
          if (!expUnrep) begin
            check("R5", refValue(d, fwd), v, $sformatf("value src%0d dst%0d in%0d", s, d, c));
            drive(d, s, fwd);
            check("R9", int'(codeOut), expNz ? refCode(s, 0) : c,
                  $sformatf("round trip src%0d dst%0d in%0d", s, d, c));
          end
        end
      end
    end

    done = 1'b1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule